// File: doc/BRIEF.md
# Load/Store Instruction Sequencer

This block is the fetch-and-execute controller of a very small 8-bit processor that owns three general registers (A, B, C) and a 16-bit program counter. It talks to memory over a synchronous bus. The bus has a 16-bit address, separate read and write strobes, an 8-bit write data path, and an 8-bit read data path. Read data is valid in the cycle after the cycle in which the read request is presented. All bus outputs are registered.

Each instruction starts with a two-cycle opcode fetch. The block then runs the instruction step by step on a small step counter. Two opcode groups are decoded, a load group and a store group. The low nibble of the opcode selects the addressing mode (immediate, absolute or register-indexed) and the register it acts on. In indexed modes the operand byte supplies the high address byte and the chosen index register supplies the low byte. When an instruction finishes, the program counter moves past its bytes and fetch begins again. Any opcode outside the two groups, and any unused slot inside them, is consumed as a one-byte no-operation, so the sequencer always keeps moving.

Top module: `ldst_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, read and write are both low. After reset, A, B and C hold 0 and the first opcode fetch reads address 0x0000.
- R2: A fetch presents a read at the program counter for one cycle. The next cycle, which is the first execute step, has no strobe active.
- R3: Opcodes 0xC0, 0xC1 and 0xC2 load A, B and C from the byte at PC+1. That operand is read in the second execute step, and the instruction is 2 bytes long.
- R4: Opcodes 0xC3, 0xC4 and 0xC5 load A, B and C from address {byte at PC+1, byte at PC+2}. The block reads PC+1, then PC+2, then that address, in three consecutive cycles. The instruction is 3 bytes long.
- R5: For load opcodes 0xC6 to 0xCE, let n = low nibble − 6. The index register is n/3 and the target register is n%3, with 0=A, 1=B and 2=C. The block reads PC+1 and then {that byte, index register value}. If the index register is also the target, its old value forms the address. The instruction is 2 bytes long.
- R6: Opcodes 0xD3, 0xD4 and 0xD5 write A, B or C to address {byte at PC+1, byte at PC+2}. The write strobe is active for exactly one cycle, in the cycle right after the PC+2 read. The instruction is 3 bytes long.
- R7: For store opcodes 0xD6 to 0xDE, the source register is n%3 and the index register is n/3, using the same n as in R5. The block writes the source value to {byte at PC+1, index value} in the cycle right after the PC+1 read. Read and write are never active together. The instruction is 2 bytes long.
- R8: The following opcodes make no bus access after the opcode fetch and advance the PC by 1: 0xCF, 0xD0, 0xD1, 0xD2, 0xDF, and every opcode whose high nibble is neither 0xC nor 0xD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Bus address, registered |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data, valid while mem_wr is high |
| mem_rdata | input | 8 | Read data, valid in the cycle after the read request |

## Verification
The bench starts with a directed prefix. This prefix stores a register straight out of reset to show that A, B and C are zero. It then loads distinct immediate values, runs a self-indexed load where the index register is also the target, and uses undefined opcodes from both groups and from outside them. After the prefix comes a long seeded-random instruction stream, weighted across every mode. Because the stream wraps a small aliased memory, stores can overwrite code and operands that are read later. This exposes any error in which byte is used as the high half and which as the low half, and any mix-up between the index and target fields. Every bus cycle is compared with a sequence that the bench predicts from its own instruction model. As a result, a wrong length, a wrong step order or a wrong register value all appear as an address or data mismatch. A second reset partway through the run checks that registers that were already loaded return to zero.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2 * DATA_W;
    localparam int NUM_REGS = 3;
    localparam int SEL_W    = 2;
    localparam int CNT_W    = 2;
    localparam int STEP_W   = 2;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam logic [3:0] GRP_LOAD  = 4'hC;
    localparam logic [3:0] GRP_STORE = 4'hD;

    typedef enum logic [1:0] {
        M_NOP = 2'd0,
        M_IMM = 2'd1,
        M_ABS = 2'd2,
        M_IDX = 2'd3
    } mode_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic             is_store;
        mode_e            mode;
        logic [SEL_W-1:0] reg_sel;
        logic [SEL_W-1:0] idx_sel;
    } dec_t;

    // Opcode decode: high nibble picks the group, low nibble picks mode and registers
    function automatic dec_t decode_op(input byte_t op);
        dec_t       d;
        logic [3:0] grp;
        logic [3:0] n;
        grp        = op[7:4];
        n          = op[3:0];
        d.is_store = (grp == GRP_STORE);
        d.mode     = M_NOP;
        d.reg_sel  = '0;
        d.idx_sel  = '0;
        if (grp == GRP_LOAD || grp == GRP_STORE) begin
            case (n)
                4'h0: if (!d.is_store) begin d.mode = M_IMM; d.reg_sel = 2'd0; end
                4'h1: if (!d.is_store) begin d.mode = M_IMM; d.reg_sel = 2'd1; end
                4'h2: if (!d.is_store) begin d.mode = M_IMM; d.reg_sel = 2'd2; end
                4'h3: begin d.mode = M_ABS; d.reg_sel = 2'd0; end
                4'h4: begin d.mode = M_ABS; d.reg_sel = 2'd1; end
                4'h5: begin d.mode = M_ABS; d.reg_sel = 2'd2; end
                4'h6: begin d.mode = M_IDX; d.idx_sel = 2'd0; d.reg_sel = 2'd0; end
                4'h7: begin d.mode = M_IDX; d.idx_sel = 2'd0; d.reg_sel = 2'd1; end
                4'h8: begin d.mode = M_IDX; d.idx_sel = 2'd0; d.reg_sel = 2'd2; end
                4'h9: begin d.mode = M_IDX; d.idx_sel = 2'd1; d.reg_sel = 2'd0; end
                4'hA: begin d.mode = M_IDX; d.idx_sel = 2'd1; d.reg_sel = 2'd1; end
                4'hB: begin d.mode = M_IDX; d.idx_sel = 2'd1; d.reg_sel = 2'd2; end
                4'hC: begin d.mode = M_IDX; d.idx_sel = 2'd2; d.reg_sel = 2'd0; end
                4'hD: begin d.mode = M_IDX; d.idx_sel = 2'd2; d.reg_sel = 2'd1; end
                4'hE: begin d.mode = M_IDX; d.idx_sel = 2'd2; d.reg_sel = 2'd2; end
                default: d.mode = M_NOP;
            endcase
        end
        return d;
    endfunction

    // Index of the final execute step for each mode
    function automatic logic [CNT_W-1:0] last_step(input mode_e m);
        case (m)
            M_IMM:   return 2'd1;
            M_ABS:   return 2'd3;
            M_IDX:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // Instruction length in bytes for each mode
    function automatic logic [STEP_W-1:0] op_len(input mode_e m);
        case (m)
            M_IMM:   return 2'd2;
            M_ABS:   return 2'd3;
            M_IDX:   return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  byte_t ir,
    output dec_t  dec
);
    always_comb dec = decode_op(ir);
endmodule

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
    parameter int NREG = 3,
    parameter int W    = 8,
    parameter int SW   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [SW-1:0]            wsel,
    input  logic [W-1:0]             wdata,
    output logic [NREG-1:0][W-1:0]   q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (we && wsel == SW'(i)) begin
                q[i] <= wdata;
            end
        end
    end
endmodule

// File: rtl/ldst_pc.sv
module ldst_pc #(
    parameter int AW = 16,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [SW-1:0] step,
    output logic [AW-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (adv) begin
            pc <= pc + AW'(step);
        end
    end
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
    import ldst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);

    phase_e                          phase_q;
    logic [CNT_W-1:0]                cnt_q;
    byte_t                           ir_q;
    byte_t                           hold_q;
    logic                            rd_q;
    logic                            wr_q;
    addr_t                           addr_q;
    byte_t                           wdata_q;

    dec_t                            dec;
    mode_e                           mode_w;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    addr_t                           pc;
    logic                            done;
    logic                            rf_we;
    byte_t                           src_val;
    byte_t                           idx_val;

    ldst_decode u_dec (
        .ir  (ir_q),
        .dec (dec)
    );

    ldst_regfile #(
        .NREG (NUM_REGS),
        .W    (DATA_W),
        .SW   (SEL_W)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .wsel  (dec.reg_sel),
        .wdata (mem_rdata),
        .q     (regs)
    );

    ldst_pc #(
        .AW (ADDR_W),
        .SW (STEP_W)
    ) u_pc (
        .clk  (clk),
        .rst  (rst),
        .adv  (done),
        .step (op_len(dec.mode)),
        .pc   (pc)
    );

    always_comb begin
        mode_w  = dec.mode;
        done    = (phase_q == PH_EXEC) && (cnt_q == last_step(dec.mode));
        rf_we   = done && !dec.is_store && (dec.mode != M_NOP);
        src_val = regs[dec.reg_sel];
        idx_val = regs[dec.idx_sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
            cnt_q   <= '0;
            ir_q    <= '0;
            hold_q  <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            case (phase_q)
                PH_FETCH: begin
                    if (cnt_q == '0) begin
                        rd_q   <= 1'b1;
                        addr_q <= pc;
                        cnt_q  <= CNT_W'(1);
                    end else begin
                        ir_q    <= mem_rdata;
                        rd_q    <= 1'b0;
                        cnt_q   <= '0;
                        phase_q <= PH_EXEC;
                    end
                end
                PH_EXEC: begin
                    if (done) begin
                        rd_q    <= 1'b0;
                        wr_q    <= 1'b0;
                        cnt_q   <= '0;
                        phase_q <= PH_FETCH;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        case (cnt_q)
                            2'd0: begin
                                rd_q   <= 1'b1;
                                addr_q <= pc + addr_t'(1);
                            end
                            2'd1: begin
                                if (dec.mode == M_ABS) begin
                                    hold_q <= mem_rdata;
                                    addr_q <= pc + addr_t'(2);
                                end else begin
                                    addr_q <= {mem_rdata, idx_val};
                                    if (dec.is_store) begin
                                        rd_q    <= 1'b0;
                                        wr_q    <= 1'b1;
                                        wdata_q <= src_val;
                                    end
                                end
                            end
                            2'd2: begin
                                addr_q <= {hold_q, mem_rdata};
                                if (dec.is_store) begin
                                    rd_q    <= 1'b0;
                                    wr_q    <= 1'b1;
                                    wdata_q <= src_val;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                default: phase_q <= PH_FETCH;
            endcase
        end
    end

    assign mem_addr  = addr_q;
    assign mem_rd    = rd_q;
    assign mem_wr    = wr_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk
    import ldst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mem_rd,
    input logic             mem_wr,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt,
    input mode_e            mode
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mem_rd && !mem_wr));

    p_exec_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && cnt == '0) |-> (!mem_rd && !mem_wr));

    p_write_single_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_write_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr) |-> $past(mem_rd));

    p_undef_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && mode == M_NOP) |=> (!mem_rd && !mem_wr));

endmodule

bind ldst_seq ldst_seq_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .phase  (phase_q),
    .cnt    (cnt_q),
    .mode   (mode_w)
);

// File: tb/ldst_seq_tb.sv
`timescale 1ns/1ps
module ldst_seq_tb_top;

    localparam int MEM_BITS = 9;
    localparam int MEM_SIZE = 1 << MEM_BITS;
    localparam int WDOG     = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem [MEM_SIZE];
    logic [7:0]  mr  [3];
    logic [15:0] mpc;
    int          tests = 0;
    int          fails = 0;
    int          cyc   = 0;
    bit          over  = 0;
    int          wp;

    always #4 clk = ~clk;

    ldst_seq dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Memory model: read data follows a registered request, writes land at the edge
    assign mem_rdata = mem_rd ? mem[mem_addr[MEM_BITS-1:0]] : 8'h00;
    always @(posedge clk) if (mem_wr) mem[mem_addr[MEM_BITS-1:0]] <= mem_wdata;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !over) begin
            over = 1;
            tests++;
            fails++;
            $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, WDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [7:0] rdm(input logic [15:0] a);
        return mem[a[MEM_BITS-1:0]];
    endfunction

    // Bench-side decode: 0 none, 1 immediate, 2 absolute, 3 indexed
    function automatic void bdec(input logic [7:0] op, output int mode, output bit st,
                                 output int r, output int ix);
        int n;
        n    = int'(op[3:0]);
        st   = (op[7:4] == 4'hD);
        mode = 0;
        r    = 0;
        ix   = 0;
        if (op[7:4] == 4'hC || op[7:4] == 4'hD) begin
            if (n <= 2 && !st) begin
                mode = 1; r = n;
            end else if (n >= 3 && n <= 5) begin
                mode = 2; r = n - 3;
            end else if (n >= 6 && n <= 14) begin
                mode = 3; ix = (n - 6) / 3; r = (n - 6) % 3;
            end
        end
    endfunction

    task automatic expect_cyc(input string tag, input bit erd, input bit ewr,
                              input logic [15:0] ea, input logic [7:0] ed);
        bit bad;
        tests++;
        bad = (mem_rd !== erd) || (mem_wr !== ewr) ||
              ((erd || ewr) && mem_addr !== ea) || (ewr && mem_wdata !== ed);
        if (bad) begin
            fails++;
            $display("FAIL %s: rd=%0b wr=%0b addr=%h wdata=%h expected rd=%0b wr=%0b addr=%h wdata=%h",
                     tag, mem_rd, mem_wr, mem_addr, mem_wdata, erd, ewr, ea, ed);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_instr(input bit first);
        logic [7:0]  op;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [15:0] ea;
        int          mode;
        int          r;
        int          ix;
        bit          st;
        op = rdm(mpc);
        bdec(op, mode, st, r, ix);
        b1 = rdm(mpc + 16'd1);
        b2 = rdm(mpc + 16'd2);
        expect_cyc("R2 fetch gap", 1'b0, 1'b0, 16'h0, 8'h0);
        expect_cyc(first ? "R1 first fetch" : "R2 fetch", 1'b1, 1'b0, mpc, 8'h0);
        expect_cyc(mode == 0 ? "R8 undefined" : "R2 exec gap", 1'b0, 1'b0, 16'h0, 8'h0);
        case (mode)
            1: begin
                mr[r] = b1;
                expect_cyc("R3 operand", 1'b1, 1'b0, mpc + 16'd1, 8'h0);
                mpc = mpc + 16'd2;
            end
            2: begin
                ea = {b1, b2};
                expect_cyc(st ? "R6 high byte" : "R4 high byte", 1'b1, 1'b0, mpc + 16'd1, 8'h0);
                expect_cyc(st ? "R6 low byte" : "R4 low byte", 1'b1, 1'b0, mpc + 16'd2, 8'h0);
                if (st) begin
                    expect_cyc("R6 write", 1'b0, 1'b1, ea, mr[r]);
                end else begin
                    mr[r] = rdm(ea);
                    expect_cyc("R4 data read", 1'b1, 1'b0, ea, 8'h0);
                end
                mpc = mpc + 16'd3;
            end
            3: begin
                ea = {b1, mr[ix]};
                expect_cyc(st ? "R7 high byte" : "R5 high byte", 1'b1, 1'b0, mpc + 16'd1, 8'h0);
                if (st) begin
                    expect_cyc("R7 write", 1'b0, 1'b1, ea, mr[r]);
                end else begin
                    mr[r] = rdm(ea);
                    expect_cyc("R5 data read", 1'b1, 1'b0, ea, 8'h0);
                end
                mpc = mpc + 16'd2;
            end
            default: mpc = mpc + 16'd1;
        endcase
    endtask

    task automatic put(input logic [7:0] v);
        mem[wp[MEM_BITS-1:0]] = v;
        wp++;
    endtask

    task automatic gen_random(input int limit);
        int k;
        while (wp < limit) begin
            k = int'($urandom % 16);
            if (k < 3) begin
                put(8'hC0 + 8'($urandom % 3)); put(8'($urandom));
            end else if (k < 5) begin
                put(8'hC3 + 8'($urandom % 3)); put(8'($urandom)); put(8'($urandom));
            end else if (k < 8) begin
                put(8'hC6 + 8'($urandom % 9)); put(8'($urandom));
            end else if (k < 10) begin
                put(8'hD3 + 8'($urandom % 3)); put(8'($urandom)); put(8'($urandom));
            end else if (k < 13) begin
                put(8'hD6 + 8'($urandom % 9)); put(8'($urandom));
            end else begin
                case ($urandom % 6)
                    0: put(8'hCF);
                    1: put(8'hD0);
                    2: put(8'hD2);
                    3: put(8'hDF);
                    default: put({4'($urandom % 12), 4'($urandom)});
                endcase
            end
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) mr[i] = 8'h00;
        mpc = 16'h0000;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_SIZE; i++) mem[i] = 8'($urandom);

        // Directed prefix
        wp = 0;
        put(8'hD3); put(8'h01); put(8'hF0);   // R1: A is zero after reset
        put(8'hC0); put(8'hAA);               // R3
        put(8'hC1); put(8'hBB);
        put(8'hC2); put(8'hCC);
        put(8'hFF); put(8'hCF); put(8'hD0); put(8'h55); // R8
        put(8'hC6); put(8'h01);               // R5: index A also target A
        put(8'hDE); put(8'h01);               // R7: store C at {01, C}
        put(8'hD9); put(8'h01);               // R7: store A at {01, B}
        put(8'hD4); put(8'h01); put(8'hE8);   // R6
        put(8'hC5); put(8'h01); put(8'hE8);   // R4: read back
        put(8'hDF);
        gen_random(MEM_SIZE - 24);

        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (mem_rd !== 1'b0 || mem_wr !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: rd=%0b wr=%0b expected rd=0 wr=0", mem_rd, mem_wr);
        end
        model_reset();
        rst = 1'b0;
        run_instr(1'b1);
        for (int i = 0; i < 300; i++) run_instr(1'b0);

        // Second reset with loaded registers
        rst = 1'b1;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        tests++;
        if (mem_rd !== 1'b0 || mem_wr !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: rd=%0b wr=%0b expected rd=0 wr=0", mem_rd, mem_wr);
        end
        wp = 0;
        put(8'hD3); put(8'h01); put(8'hF1);   // R1: A cleared
        put(8'hD4); put(8'h01); put(8'hF2);   // R1: B cleared
        put(8'hD5); put(8'h01); put(8'hF3);   // R1: C cleared
        put(8'hCC); put(8'h01);               // R5: index C, target A
        model_reset();
        rst = 1'b0;
        run_instr(1'b1);
        for (int i = 0; i < 60; i++) run_instr(1'b0);

        over = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule